// File: doc/BRIEF.md
# Clause Row Implication and Conflict Unit

This block is one clause row of a parallel Boolean constraint propagation array. The row holds one cell per variable column, and each cell stores a 2-bit literal code that says whether, and with which polarity, its variable appears in the clause. Each column presents a 3-bit variable status: a high-value line, a low-value line and an implied flag. From these the row works out four things: whether the clause is satisfied, whether it has become a unit clause, which free literal it must imply, and whether it is in conflict.

The row returns per-column drive contributions on the same three lines. The array ORs these with the contributions of every other row before they reach the variable columns. Everything from status to drive is static combinational logic. The only state is the set of stored literal codes, which a simple indexed write port loads. A 2-bit free-literal count ripples along the row and saturates at 3. A termination stage at the end of the row turns that count into an implication request or a conflict.

Top module: `clause_row_bcp`

## Requirements
- R1: After reset every stored code is 00 (absent). The row then reports free count 0, not satisfied, no implication, conflict high, and all drive outputs low.
- R2: When wr_en_i is high at a rising clock edge, the code at column wr_idx_i is replaced by wr_code_i and all other columns keep their codes. When wr_en_i is low, no code changes.
- R3: The literal code is {positive bit, negative bit}: 10 is a positive literal and 01 is a negative literal. sat_o is high when a cell with code 10 or 01 sees its variable's {hi,lo} lines equal to its code.
- R4: A cell is free when its code is 10 or 01 and its status {hi,lo,imp} is 000. free_cnt_o is the number of free cells, saturated at 3.
- R5: unit_o is high exactly when free_cnt_o is 1 and sat_o is low.
- R6: While unit_o is high, the single free cell drives its code onto drv_hi_o/drv_lo_o and raises drv_imp_o for its column. Each free cell drives only when this happens or when conflict_o is high.
- R7: conflict_o is high when free_cnt_o is 0 and sat_o is low.
- R8: conflict_o is also high when unit_o is high and some cell with code 10 or 01 sees status {hi,lo} = 11.
- R9: While conflict_o is high, every cell with code 10 or 01 drives its code onto drv_hi_o/drv_lo_o. drv_imp_o stays low, except on the free cell while unit_o is high.
- R10: Cells with code 00 or 11 are never free, never satisfy the clause and never drive.
- R11: While sat_o is high, unit_o and conflict_o are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the code registers |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Code write enable |
| wr_idx_i | input | IDX_W | Column whose code is written |
| wr_code_i | input | 2 | Literal code {pos,neg} to store |
| var_hi_i | input | N | Value-high line for each column |
| var_lo_i | input | N | Value-low line for each column |
| var_imp_i | input | N | Implied flag for each column |
| drv_hi_o | output | N | High-line drive contribution |
| drv_lo_o | output | N | Low-line drive contribution |
| drv_imp_o | output | N | Implied-flag drive contribution |
| free_cnt_o | output | 2 | Saturating free-literal count |
| sat_o | output | 1 | Clause satisfied |
| unit_o | output | 1 | Unit clause, implication requested |
| conflict_o | output | 1 | Clause in conflict |

## Verification
The assertions take for granted that the status inputs are defined from the first clock edge after reset, and that wr_idx_i names an existing column when a write is enabled. They also take for granted that the illegal status 001 may appear without breaking any property, because a cell with that status is neither free nor satisfying. The stimulus drives every status vector and write at the falling edge and never addresses a column beyond N-1. It deliberately presents the illegal literal code 11 together with the matching status 110, to show that the code is inert.

// File: rtl/clause_row_pkg.sv
package clause_row_pkg;
  typedef logic [1:0] lit_code_t;
  typedef logic [1:0] free_cnt_t;

  localparam lit_code_t CODE_ABSENT = 2'b00;
  localparam lit_code_t CODE_POS    = 2'b10;
  localparam lit_code_t CODE_NEG    = 2'b01;

  function automatic free_cnt_t cnt_sat_inc(input free_cnt_t c);
    return (c == 2'd3) ? c : c + 2'd1;
  endfunction

  function automatic logic code_legal(input lit_code_t c);
    return c[1] ^ c[0];
  endfunction
endpackage

// File: rtl/clause_cell.sv
module clause_cell
  import clause_row_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  lit_code_t wr_code_i,
  input  logic      var_hi_i,
  input  logic      var_lo_i,
  input  logic      var_imp_i,
  input  free_cnt_t cnt_i,
  output free_cnt_t cnt_o,
  input  logic      imp_drv_i,
  input  logic      cclause_i,
  output logic      sat_o,
  output logic      conf_o,
  output logic      drv_hi_o,
  output logic      drv_lo_o,
  output logic      drv_imp_o
);
  lit_code_t code_q;
  logic      part, free, drv_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   code_q <= CODE_ABSENT;
    else if (wr_i) code_q <= wr_code_i;
  end

  assign part     = code_legal(code_q);
  assign free     = part & ~var_hi_i & ~var_lo_i & ~var_imp_i;
  assign cnt_o    = free ? cnt_sat_inc(cnt_i) : cnt_i;
  assign sat_o    = part & ({var_hi_i, var_lo_i} == code_q);
  assign conf_o   = part & var_hi_i & var_lo_i & imp_drv_i;
  assign drv_data = part & (cclause_i | (imp_drv_i & free));
  assign drv_hi_o = drv_data & code_q[1];
  assign drv_lo_o = drv_data & code_q[0];
  assign drv_imp_o = imp_drv_i & free;

  // R10: absent or illegal code stays inert
  assert_inert_code_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !code_legal(code_q) |-> !sat_o && !drv_hi_o && !drv_lo_o && !drv_imp_o && cnt_o == cnt_i);

  // R2: code holds without a write
  assert_code_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(code_q));
endmodule

// File: rtl/clause_term.sv
module clause_term
  import clause_row_pkg::*;
(
  input  free_cnt_t cnt_i,
  input  logic      sat_i,
  output logic      imp_drv_o,
  output logic      conf_o
);
  assign imp_drv_o = ~sat_i & (cnt_i == 2'd1);
  assign conf_o    = ~sat_i & (cnt_i == 2'd0);
endmodule

// File: rtl/clause_row_bcp.sv
module clause_row_bcp
  import clause_row_pkg::*;
#(
  parameter int N     = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [1:0]       wr_code_i,
  input  logic [N-1:0]     var_hi_i,
  input  logic [N-1:0]     var_lo_i,
  input  logic [N-1:0]     var_imp_i,
  output logic [N-1:0]     drv_hi_o,
  output logic [N-1:0]     drv_lo_o,
  output logic [N-1:0]     drv_imp_o,
  output logic [1:0]       free_cnt_o,
  output logic             sat_o,
  output logic             unit_o,
  output logic             conflict_o
);
  free_cnt_t    cnt [N+1];
  logic [N-1:0] cell_sat, cell_conf;
  logic         imp_drv, term_conf, cclause;

  assign cnt[0] = 2'd0;

  for (genvar i = 0; i < N; i++) begin : g_cell
    clause_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_en_i && (wr_idx_i == IDX_W'(i))),
      .wr_code_i (wr_code_i),
      .var_hi_i  (var_hi_i[i]),
      .var_lo_i  (var_lo_i[i]),
      .var_imp_i (var_imp_i[i]),
      .cnt_i     (cnt[i]),
      .cnt_o     (cnt[i+1]),
      .imp_drv_i (imp_drv),
      .cclause_i (cclause),
      .sat_o     (cell_sat[i]),
      .conf_o    (cell_conf[i]),
      .drv_hi_o  (drv_hi_o[i]),
      .drv_lo_o  (drv_lo_o[i]),
      .drv_imp_o (drv_imp_o[i])
    );
  end

  clause_term u_term (
    .cnt_i     (cnt[N]),
    .sat_i     (sat_o),
    .imp_drv_o (imp_drv),
    .conf_o    (term_conf)
  );

  assign sat_o      = |cell_sat;
  assign cclause    = term_conf | (|cell_conf);
  assign free_cnt_o = cnt[N];
  assign unit_o     = imp_drv;
  assign conflict_o = cclause;

  // R11: a satisfied clause is quiet
  assert_sat_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o |-> !unit_o && !conflict_o);

  // R6: at most one implied column per row
  assert_single_imply_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(drv_imp_o));

  // R6: implication drive only with a unit clause
  assert_imp_needs_unit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_imp_o != '0) |-> unit_o);

  // R7: an unsatisfied clause with no free literal is in conflict
  assert_empty_conflict_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_cnt_o == 2'd0 && !sat_o) |-> conflict_o);

  // R9: a data drive without a unit clause means conflict
  assert_drive_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((drv_hi_o | drv_lo_o) != '0 && !unit_o) |-> conflict_o);
endmodule

// File: tb/sim_clause_row_bcp.sv
`timescale 1ns/1ps
module sim_clause_row_bcp;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_idx = '0;
  logic [1:0]   wr_code = '0;
  logic [N-1:0] v_hi = '0, v_lo = '0, v_imp = '0;
  logic [N-1:0] d_hi, d_lo, d_imp;
  logic [1:0]   fcnt;
  logic         sat, unit, conf;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clause_row_bcp #(.N(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_code_i(wr_code), .var_hi_i(v_hi), .var_lo_i(v_lo), .var_imp_i(v_imp),
    .drv_hi_o(d_hi), .drv_lo_o(d_lo), .drv_imp_o(d_imp), .free_cnt_o(fcnt),
    .sat_o(sat), .unit_o(unit), .conflict_o(conf)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic row_chk(input string req, input logic [1:0] e_cnt, input logic e_sat,
                         input logic e_unit, input logic e_conf, input logic [3:0] e_hi,
                         input logic [3:0] e_lo, input logic [3:0] e_imp);
    chk(req, "free_cnt", 8'(fcnt), 8'(e_cnt));
    chk(req, "sat", 8'(sat), 8'(e_sat));
    chk(req, "unit", 8'(unit), 8'(e_unit));
    chk(req, "conflict", 8'(conf), 8'(e_conf));
    chk(req, "drv_hi", 8'(d_hi), 8'(e_hi));
    chk(req, "drv_lo", 8'(d_lo), 8'(e_lo));
    chk(req, "drv_imp", 8'(d_imp), 8'(e_imp));
  endtask

  task automatic write_code(input int idx, input logic [1:0] code, input logic en);
    @(negedge clk);
    wr_idx = 2'(idx); wr_code = code; wr_en = en;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // status per column as {hi,lo,imp}
  task automatic set_status(input logic [2:0] s0, input logic [2:0] s1,
                            input logic [2:0] s2, input logic [2:0] s3);
    @(negedge clk);
    v_hi  = {s3[2], s2[2], s1[2], s0[2]};
    v_lo  = {s3[1], s2[1], s1[1], s0[1]};
    v_imp = {s3[0], s2[0], s1[0], s0[0]};
    #2;
  endtask

  task automatic t_reset;
    set_status(3'b000, 3'b000, 3'b000, 3'b000);
    row_chk("R1", 2'd0, 0, 0, 1, 4'b0000, 4'b0000, 4'b0000);
  endtask

  task automatic t_load_all_free;
    write_code(0, 2'b10, 1);
    write_code(1, 2'b01, 1);
    write_code(3, 2'b10, 1);
    set_status(3'b000, 3'b000, 3'b000, 3'b000);
    // R4: three free cells, absent column 2 not counted (R10)
    row_chk("R4", 2'd3, 0, 0, 0, 4'b0000, 4'b0000, 4'b0000);
  endtask

  task automatic t_unit;
    set_status(3'b010, 3'b000, 3'b000, 3'b000);
    row_chk("R4", 2'd2, 0, 0, 0, 4'b0000, 4'b0000, 4'b0000);
    set_status(3'b010, 3'b000, 3'b000, 3'b010);
    // R5 / R6: column 1 negative literal implied
    row_chk("R6", 2'd1, 0, 1, 0, 4'b0000, 4'b0010, 4'b0010);
  endtask

  task automatic t_satisfied;
    set_status(3'b010, 3'b011, 3'b000, 3'b010);
    row_chk("R3", 2'd0, 1, 0, 0, 4'b0000, 4'b0000, 4'b0000);
    set_status(3'b101, 3'b000, 3'b000, 3'b000);
    // R11: satisfied with free literals left, still quiet
    row_chk("R11", 2'd2, 1, 0, 0, 4'b0000, 4'b0000, 4'b0000);
  endtask

  task automatic t_term_conflict;
    set_status(3'b010, 3'b100, 3'b000, 3'b010);
    // R7 / R9: every participating literal driven, no implied flag
    row_chk("R9", 2'd0, 0, 0, 1, 4'b1001, 4'b0010, 4'b0000);
  endtask

  task automatic t_cell_conflict;
    set_status(3'b000, 3'b111, 3'b000, 3'b010);
    // R8: count one, column 1 in conflict
    row_chk("R8", 2'd1, 0, 1, 1, 4'b1001, 4'b0010, 4'b0001);
  endtask

  task automatic t_illegal_code;
    write_code(2, 2'b11, 1);
    set_status(3'b010, 3'b100, 3'b000, 3'b010);
    row_chk("R10", 2'd0, 0, 0, 1, 4'b1001, 4'b0010, 4'b0000);
    set_status(3'b010, 3'b100, 3'b110, 3'b010);
    row_chk("R10", 2'd0, 0, 0, 1, 4'b1001, 4'b0010, 4'b0000);
  endtask

  task automatic t_write_port;
    write_code(2, 2'b10, 0);
    set_status(3'b010, 3'b100, 3'b100, 3'b010);
    // R2: disabled write leaves code 11, so no satisfaction
    row_chk("R2", 2'd0, 0, 0, 1, 4'b1001, 4'b0010, 4'b0000);
    write_code(2, 2'b10, 1);
    set_status(3'b010, 3'b100, 3'b100, 3'b010);
    row_chk("R2", 2'd0, 1, 0, 0, 4'b0000, 4'b0000, 4'b0000);
    set_status(3'b010, 3'b100, 3'b010, 3'b000);
    // R2: other columns kept their codes; column 3 implied positive
    row_chk("R2", 2'd1, 0, 1, 0, 4'b1000, 4'b0000, 4'b1000);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_load_all_free;
    t_unit;
    t_satisfied;
    t_term_conflict;
    t_cell_conflict;
    t_illegal_code;
    t_write_port;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule